// File: doc/BRIEF.md
# Dual-Rail Early-Output AND Stage

This block computes the logical AND of several dual-rail, delay-insensitive operands and drives the result on a dual-rail output channel. Each channel carries a two-wire code. A four-phase return-to-zero handshake paces it: data appears, is acknowledged, goes back to NULL, and the acknowledge drops before the next data word.

The result leaves as soon as it is decided. A single operand carrying a zero settles the output to zero while the other operands may still be NULL. A one is produced only when every operand carries a one. Completion detection is kept separate from output generation. The validity signal and the input acknowledge wait until every operand has arrived, so an operand that comes late is never acknowledged before it exists.

The hysteresis elements are modelled as registers updated on a free-running sampling clock. Each decision therefore appears one sampling edge after its condition holds. A sticky flag reports any channel that carries the forbidden code.

Top module: `eo_and_stage`

## Requirements
- R1: Every channel uses bit 0 as the zero rail and bit 1 as the one rail: 00 is NULL, 01 is logic zero, 10 is logic one. The output channel `y_rails` never carries 11.
- R2: While `y_rails` is NULL and `out_ack` is low, any operand equal to 01 makes `y_rails` equal 01 one sampling edge later, whatever the other operands hold.
- R3: `y_rails` becomes 10 only one edge after every operand equals 10. With some operands still NULL and no zero present, it stays NULL.
- R4: `valid` rises one edge after every operand is non-NULL and falls one edge after every operand is NULL. In any other mix it holds its value.
- R5: `in_ack` rises one edge after `valid` is high while `y_rails` is non-NULL. It falls one edge after `valid` is low while `y_rails` is NULL. It never rises while an operand is still missing.
- R6: A non-NULL `y_rails` returns to NULL one edge after every operand is NULL and `out_ack` is high. Until then it holds, even with `out_ack` high.
- R7: While `out_ack` is high and `y_rails` is NULL, no new result is produced.
- R8: `bad_code` goes high one edge after any operand carries 11 and stays high until reset.
- R9: Synchronous reset drives `y_rails` to NULL and clears `valid`, `in_ack` and `bad_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_rails | input | 2*NUM_IN | Operand channels, operand i on bits 2i+1:2i |
| out_ack | input | 1 | Acknowledge from the downstream consumer |
| y_rails | output | 2 | Dual-rail AND result |
| valid | output | 1 | Completion: all operands present |
| in_ack | output | 1 | Acknowledge shared by all operand channels |
| bad_code | output | 1 | Sticky illegal-code indicator |

## Verification
The hardest case to reach is an early zero on the output while a partner operand is still NULL and `in_ack` must stay low. It is harder still when `out_ack` rises before the late operand arrives, so the output cannot reset and the acknowledge is still waiting. The directed part holds one operand back for several cycles after a zero. Random transactions then draw independent arrival and withdrawal delays per operand and a random downstream acknowledge latency. A cycle model built from the requirements is compared with every output on every cycle.

// File: rtl/eo_and_pkg.sv
package eo_and_pkg;
   typedef enum logic [1:0] {
      DR_NULL = 2'b00,
      DR_ZERO = 2'b01,
      DR_ONE  = 2'b10,
      DR_BAD  = 2'b11
   } dr_code_t;

   localparam int DR_W = 2;
endpackage

// File: rtl/eo_and_classify.sv
module eo_and_classify
   import eo_and_pkg::*;
#(
   parameter int NUM_IN = 2
) (
   input  logic [DR_W*NUM_IN-1:0] rails,
   output logic                   any_zero,
   output logic                   all_one,
   output logic                   all_set,
   output logic                   all_null,
   output logic                   any_bad
);
   logic [NUM_IN-1:0] is_zero, is_one, is_set, is_bad;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
      logic [DR_W-1:0] code;
      assign code       = rails[DR_W*i +: DR_W];
      assign is_zero[i] = (code == DR_ZERO);
      assign is_one[i]  = (code == DR_ONE);
      assign is_set[i]  = (code != DR_NULL);
      assign is_bad[i]  = (code == DR_BAD);
   end

   assign any_zero = |is_zero;
   assign all_one  = &is_one;
   assign all_set  = &is_set;
   assign all_null = ~|is_set;
   assign any_bad  = |is_bad;
endmodule

// File: rtl/eo_and_celem.sv
module eo_and_celem (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)        q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(set_i && clr_i));  // R4
endmodule

// File: rtl/eo_and_out_reg.sv
module eo_and_out_reg
   import eo_and_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            any_zero,
   input  logic            all_one,
   input  logic            all_null,
   input  logic            out_ack,
   output logic [DR_W-1:0] y
);
   logic y_idle;
   assign y_idle = (y == DR_NULL);

   always_ff @(posedge clk) begin
      if (rst) begin
         y <= DR_NULL;
      end else if (y_idle) begin
         if (!out_ack) begin
            if (any_zero)     y <= DR_ZERO;
            else if (all_one) y <= DR_ONE;
         end
      end else if (all_null && out_ack) begin
         y <= DR_NULL;
      end
   end

   AST_Y_LEGAL: assert property (@(posedge clk) disable iff (rst)
      y != DR_BAD);  // R1
   AST_NO_NEW_DURING_ACK: assert property (@(posedge clk) disable iff (rst)
      (y_idle && out_ack) |=> (y == DR_NULL));  // R7
endmodule

// File: rtl/eo_and_stage.sv
module eo_and_stage
   import eo_and_pkg::*;
#(
   parameter int NUM_IN = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [DR_W*NUM_IN-1:0] in_rails,
   input  logic                   out_ack,
   output logic [DR_W-1:0]        y_rails,
   output logic                   valid,
   output logic                   in_ack,
   output logic                   bad_code
);
   if (NUM_IN < 2) begin : g_chk_num
      $error("eo_and_stage: NUM_IN must be at least 2");
   end

   logic any_zero, all_one, all_set, all_null, any_bad;
   logic y_set;

   eo_and_classify #(.NUM_IN(NUM_IN)) u_cls (
      .rails    (in_rails),
      .any_zero (any_zero),
      .all_one  (all_one),
      .all_set  (all_set),
      .all_null (all_null),
      .any_bad  (any_bad)
   );

   eo_and_out_reg u_out (
      .clk      (clk),
      .rst      (rst),
      .any_zero (any_zero),
      .all_one  (all_one),
      .all_null (all_null),
      .out_ack  (out_ack),
      .y        (y_rails)
   );

   assign y_set = (y_rails != DR_NULL);

   eo_and_celem u_valid (
      .clk   (clk),
      .rst   (rst),
      .set_i (all_set),
      .clr_i (all_null),
      .q     (valid)
   );

   eo_and_celem u_ack (
      .clk   (clk),
      .rst   (rst),
      .set_i (valid && y_set),
      .clr_i (!valid && !y_set),
      .q     (in_ack)
   );

   always_ff @(posedge clk) begin
      if (rst)          bad_code <= 1'b0;
      else if (any_bad) bad_code <= 1'b1;
   end

   AST_ZERO_EARLY: assert property (@(posedge clk) disable iff (rst)
      (!y_set && !out_ack && any_zero) |=> (y_rails == DR_ZERO));  // R2
   AST_ONE_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
      ($past(y_rails) == DR_NULL && y_rails == DR_ONE) |-> $past(all_one));  // R3
   AST_VALID_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
      $rose(valid) |-> $past(all_set));  // R4
   AST_ACK_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
      $rose(in_ack) |-> $past(valid && y_set));  // R5
   AST_RTZ_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
      $fell(y_set) |-> $past(all_null && out_ack));  // R6
   AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
      bad_code |=> bad_code);  // R8
endmodule

// File: tb/eo_and_stage_tb.sv
module eo_and_stage_tb;
   localparam int NUM_IN = 2;
   localparam logic [1:0] NUL = 2'b00, ZER = 2'b01, ONE = 2'b10, BAD = 2'b11;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2*NUM_IN-1:0] in_rails = '0;
   logic out_ack = 1'b0;
   logic [1:0] y_rails;
   logic valid, in_ack, bad_code;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   bit auto_ds = 1'b0;

   logic [1:0] e_y;
   logic e_valid, e_ack, e_bad;

   always #5 clk = ~clk;

   eo_and_stage #(.NUM_IN(NUM_IN)) u_dut (
      .clk(clk), .rst(rst), .in_rails(in_rails), .out_ack(out_ack),
      .y_rails(y_rails), .valid(valid), .in_ack(in_ack), .bad_code(bad_code)
   );

   function automatic bit f_any_zero(input logic [2*NUM_IN-1:0] r);
      for (int i = 0; i < NUM_IN; i++) if (r[2*i +: 2] == ZER) return 1'b1;
      return 1'b0;
   endfunction
   function automatic bit f_all_one(input logic [2*NUM_IN-1:0] r);
      for (int i = 0; i < NUM_IN; i++) if (r[2*i +: 2] != ONE) return 1'b0;
      return 1'b1;
   endfunction
   function automatic bit f_all_set(input logic [2*NUM_IN-1:0] r);
      for (int i = 0; i < NUM_IN; i++) if (r[2*i +: 2] == NUL) return 1'b0;
      return 1'b1;
   endfunction
   function automatic bit f_any_bad(input logic [2*NUM_IN-1:0] r);
      for (int i = 0; i < NUM_IN; i++) if (r[2*i +: 2] == BAD) return 1'b1;
      return 1'b0;
   endfunction

   // Expected-value model, built from R1-style rules per requirement
   always @(posedge clk) begin
      if (rst) begin
         e_y <= NUL; e_valid <= 1'b0; e_ack <= 1'b0; e_bad <= 1'b0;
      end else begin
         if (e_y == NUL) begin
            if (!out_ack && f_any_zero(in_rails)) e_y <= ZER;          // R2
            else if (!out_ack && f_all_one(in_rails)) e_y <= ONE;      // R3
         end else if (in_rails == '0 && out_ack) e_y <= NUL;           // R6
         if (f_all_set(in_rails)) e_valid <= 1'b1;                     // R4
         else if (in_rails == '0) e_valid <= 1'b0;
         if (e_valid && e_y != NUL) e_ack <= 1'b1;                     // R5
         else if (!e_valid && e_y == NUL) e_ack <= 1'b0;
         if (f_any_bad(in_rails)) e_bad <= 1'b1;                       // R8
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         check("R2/R3/R6 y", {30'd0, y_rails}, {30'd0, e_y});
         check("R1 y legal", {31'd0, y_rails == BAD}, 32'd0);
         check("R4 valid", {31'd0, valid}, {31'd0, e_valid});
         check("R5 in_ack", {31'd0, in_ack}, {31'd0, e_ack});
         check("R8 bad_code", {31'd0, bad_code}, {31'd0, e_bad});
      end
   end

   // Random downstream consumer
   always @(negedge clk) begin
      if (auto_ds) begin
         if (y_rails != NUL && !out_ack && ($urandom % 3 == 0)) out_ack = 1'b1;
         else if (y_rails == NUL && out_ack && ($urandom % 3 == 0)) out_ack = 1'b0;
      end
   end

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic set_in(input logic [1:0] a, input logic [1:0] b);
      in_rails = {b, a};
   endtask

   task automatic do_reset();
      rst = 1'b1; in_rails = '0; out_ack = 1'b0;
      cyc(2);
      rst = 1'b0;
      cyc(1);
   endtask

   task automatic random_txn();
      logic [1:0] val [NUM_IN];
      int dly [NUM_IN];
      int t;
      for (int i = 0; i < NUM_IN; i++) begin
         val[i] = ($urandom % 2) ? ONE : ZER;
         dly[i] = $urandom % 6;
      end
      t = 0;
      while (in_ack && t < 200) begin cyc(1); t++; end
      t = 0;
      while (!in_ack && t < 200) begin
         for (int i = 0; i < NUM_IN; i++) if (t >= dly[i]) in_rails[2*i +: 2] = val[i];
         cyc(1); t++;
      end
      if (t >= 200) check("R5 handshake timeout", 32'd1, 32'd0);
      cyc($urandom % 3);
      for (int i = 0; i < NUM_IN; i++) dly[i] = $urandom % 4;
      t = 0;
      while (in_ack && t < 200) begin
         for (int i = 0; i < NUM_IN; i++) if (t >= dly[i]) in_rails[2*i +: 2] = NUL;
         cyc(1); t++;
      end
      if (t >= 200) check("R6 return-to-zero timeout", 32'd1, 32'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #1ms;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5150));
      cyc(2);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      check("R9 y", {30'd0, y_rails}, 32'd0);
      check("R9 valid", {31'd0, valid}, 32'd0);
      check("R9 in_ack", {31'd0, in_ack}, 32'd0);
      check("R9 bad_code", {31'd0, bad_code}, 32'd0);

      // R2 early zero with b absent; R5 ack waits for b
      set_in(ZER, NUL); cyc(1);
      check("R2 early zero", {30'd0, y_rails}, {30'd0, ZER});
      cyc(3);
      check("R5 no ack while b missing", {31'd0, in_ack}, 32'd0);
      check("R4 no valid while b missing", {31'd0, valid}, 32'd0);
      out_ack = 1'b1; cyc(2);
      check("R6 hold while inputs present", {30'd0, y_rails}, {30'd0, ZER});
      set_in(ZER, ONE); cyc(1);
      check("R4 valid after last arrival", {31'd0, valid}, 32'd1);
      check("R5 ack one edge after valid", {31'd0, in_ack}, 32'd0);
      cyc(1);
      check("R5 ack raised", {31'd0, in_ack}, 32'd1);
      set_in(NUL, NUL); cyc(1);
      check("R6 output back to NULL", {30'd0, y_rails}, 32'd0);
      check("R4 valid cleared", {31'd0, valid}, 32'd0);
      cyc(1);
      check("R5 ack released", {31'd0, in_ack}, 32'd0);
      out_ack = 1'b0;

      // R3 no early result on a lone one
      set_in(NUL, ONE); cyc(2);
      check("R3 lone one stays NULL", {30'd0, y_rails}, 32'd0);
      set_in(ONE, ONE); cyc(1);
      check("R3 both ones", {30'd0, y_rails}, {30'd0, ONE});
      cyc(1);
      out_ack = 1'b1;
      set_in(NUL, ONE); cyc(2);
      check("R6 hold with one operand left", {30'd0, y_rails}, {30'd0, ONE});
      check("R4 valid holds on partial NULL", {31'd0, valid}, 32'd1);
      set_in(NUL, NUL); cyc(1);
      check("R6 NULL after both withdrawn", {30'd0, y_rails}, 32'd0);
      cyc(1);
      // R7 out_ack still high: no new result
      set_in(ZER, NUL); cyc(2);
      check("R7 no result while out_ack high", {30'd0, y_rails}, 32'd0);
      out_ack = 1'b0; cyc(1);
      check("R2 zero after out_ack release", {30'd0, y_rails}, {30'd0, ZER});

      // Random transactions in every arrival order
      do_reset();
      auto_ds = 1'b1;
      for (int n = 0; n < 400; n++) random_txn();
      auto_ds = 1'b0;

      // R8 illegal code flag
      do_reset();
      set_in(BAD, NUL); cyc(1);
      check("R8 flag set", {31'd0, bad_code}, 32'd1);
      set_in(NUL, NUL); cyc(3);
      check("R8 flag sticky", {31'd0, bad_code}, 32'd1);
      rst = 1'b1; cyc(1);
      rst = 1'b0; cyc(1);
      check("R9 reset clears flag", {31'd0, bad_code}, 32'd0);
      finish_run();
   end
endmodule